// File: doc/BRIEF.md
# I2C Target with SMBus Quick-Command Detection

This block is the target (responding) side of an I2C bus with a 7-bit device address. It synchronizes the bus clock and data lines into the system clock domain, finds START and STOP conditions, compares the address byte against its own address and acknowledges a match. Written bytes arrive on a receive register. Read bytes come from a one-entry transmit buffer that local logic fills.

On top of ordinary byte transfers, the block recognises the SMBus quick command. In this transaction the read/write bit of the address byte is the whole message. When a STOP ends an addressed transaction in which no data byte was completed, the block marks the transaction as a quick command and records the direction bit. In the read direction the block raises its data request at the address acknowledge and holds SCL low until local logic supplies a byte. That byte must have its top bit set, so that SDA stays released and the controller can place a STOP in the first data slot. Local logic sees two raw interrupt flags (data, stop) and clears them by writing ones.

Top module: `i2cq_target`

## Requirements
- R1: While reset is asserted and right after it, all four flags, `rxData`, `sdaOe` and `sclOe` are 0.
- R2: An address byte whose upper seven bits equal `devAddr` is acknowledged by pulling SDA low in the ninth slot. A non-matching address is not acknowledged and its STOP sets no flag.
- R3: In a write transaction, each received byte (MSB first) appears on `rxData`, is acknowledged, and sets `dataRis`.
- R4: An addressed write (read/write bit 0) ended by STOP with no complete data byte sets `qcmdSt`=1, `qcmdDir`=0 and `stopRis`=1, and leaves `dataRis` at 0.
- R5: An addressed read (read/write bit 1) sets `dataRis` at the address acknowledge. If it is then ended by STOP in the first data slot, `qcmdSt`=1, `qcmdDir`=1 and `stopRis`=1.
- R6: After the acknowledge of a read address, and after each acknowledged read byte, `sclOe` stays 1 until a byte is written with `txWr`. A byte written before that point is used without holding SCL.
- R7: Read bytes are driven MSB first. A 1 bit releases SDA, and a 0 bit pulls it low. A not-acknowledge from the controller ends the transfer.
- R8: An addressed transaction that completes one or more data bytes leaves `qcmdSt` at 0 after its STOP.
- R9: `qcmdSt` and `qcmdDir` are cleared only by reset or by the acknowledge of a matching address. Other transactions and flag clears leave them unchanged. `qcmdDir` is never 1 while `qcmdSt` is 0.
- R10: A `clrWr` pulse clears `dataRis` where `clrMask[0]`=1 and `stopRis` where `clrMask[1]`=1, each independently. A flag being set in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| devAddr | input | 7 | Own 7-bit bus address |
| sclIn | input | 1 | Bus clock line as seen on the pin |
| sdaIn | input | 1 | Bus data line as seen on the pin |
| sclOe | output | 1 | 1 pulls SCL low (hold for transmit data) |
| sdaOe | output | 1 | 1 pulls SDA low (acknowledge or 0 data bit) |
| txWr | input | 1 | Load strobe for the transmit byte |
| txData | input | 8 | Transmit byte |
| clrWr | input | 1 | Flag clear strobe |
| clrMask | input | 2 | Bit 0 clears dataRis, bit 1 clears stopRis |
| rxData | output | 8 | Last received byte |
| dataRis | output | 1 | Raw data flag: byte received or byte requested |
| stopRis | output | 1 | Raw stop flag for an addressed transaction |
| qcmdSt | output | 1 | Last addressed transaction was a quick command |
| qcmdDir | output | 1 | Read/write bit of that quick command |

## Verification
The main function is tried with the quick write and the one-byte write back to back. They differ only in whether a data byte completes before STOP, so they separate a byte-count classifier from one that looks at the direction alone. The quick read and the one-byte read are paired in the same way. In the quick read the transmit byte is preloaded once and left unloaded once, which exposes the SCL hold and its release on a write. A wrong-address transaction placed right after a quick command shows that the status survives a transaction that does not match, and a two-byte write shows that receive bytes are ordered MSB first.

// File: rtl/i2cq_pkg.sv
package i2cq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_END,
    ST_ACK_A,
    ST_WAIT_TX,
    ST_TX,
    ST_TX_ACK,
    ST_TX_NEXT,
    ST_RX,
    ST_RX_END,
    ST_ACK_R
  } tgtState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic shiftIn;
    logic clrCnt;
    logic latchRw;
    logic latchRx;
    logic loadTx;
    logic shiftTx;
    logic drvAck;
    logic drvTx;
  } dpCtl_t;

  localparam int CLR_DATA_BIT = 0;
  localparam int CLR_STOP_BIT = 1;

endpackage

// File: rtl/i2cq_datapath.sv
module i2cq_datapath
  import i2cq_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [ADDR_W-1:0] devAddr,
  input  logic              txWr,
  input  logic [DATA_W-1:0] txData,
  input  dpCtl_t            ctl,
  output logic              sclRise,
  output logic              sclFall,
  output logic              startSeen,
  output logic              stopSeen,
  output logic              sdaBit,
  output logic              cntLast,
  output logic              addrHit,
  output logic              rwBit,
  output logic              txFull,
  output logic [DATA_W-1:0] rxData,
  output logic              sdaOe
);

  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(DATA_W - 1);

  logic [SYNC_STAGES-1:0] sclSync;
  logic [SYNC_STAGES-1:0] sdaSync;
  logic sclS, sdaS, sclPrev, sdaPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[SYNC_STAGES-2:0], sclIn};
      sdaSync <= {sdaSync[SYNC_STAGES-2:0], sdaIn};
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end
  end

  assign sclS      = sclSync[SYNC_STAGES-1];
  assign sdaS      = sdaSync[SYNC_STAGES-1];
  assign sclRise   = sclS & ~sclPrev;
  assign sclFall   = ~sclS & sclPrev;
  assign startSeen = sclS & sclPrev & sdaPrev & ~sdaS;
  assign stopSeen  = sclS & sclPrev & ~sdaPrev & sdaS;
  assign sdaBit    = sdaS;

  logic [DATA_W-1:0] rxShift;
  logic [CNT_W-1:0]  bitCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      bitCnt  <= '0;
      rwBit   <= 1'b0;
      rxData  <= '0;
    end else begin
      if (ctl.shiftIn) rxShift <= {rxShift[DATA_W-2:0], sdaS};
      if (ctl.clrCnt) bitCnt <= '0;
      else if (ctl.shiftIn || ctl.shiftTx) bitCnt <= bitCnt + 1'b1;
      if (ctl.latchRw) rwBit <= rxShift[0];
      if (ctl.latchRx) rxData <= {rxShift[DATA_W-2:0], sdaS};
    end
  end

  assign cntLast = (bitCnt == LAST_CNT);
  assign addrHit = (rxShift[DATA_W-1 -: ADDR_W] == devAddr);

  logic [DATA_W-1:0] txBuf;
  logic [DATA_W-1:0] txShift;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txBuf   <= '0;
      txFull  <= 1'b0;
      txShift <= '1;
    end else begin
      if (txWr) begin
        txBuf  <= txData;
        txFull <= 1'b1;
      end else if (ctl.loadTx) begin
        txFull <= 1'b0;
      end
      if (ctl.loadTx) txShift <= txBuf;
      else if (ctl.shiftTx) txShift <= {txShift[DATA_W-2:0], 1'b1};
    end
  end

  assign sdaOe = ctl.drvAck | (ctl.drvTx & ~txShift[DATA_W-1]);

endmodule

// File: rtl/i2cq_control.sv
module i2cq_control
  import i2cq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclRise,
  input  logic       sclFall,
  input  logic       startSeen,
  input  logic       stopSeen,
  input  logic       sdaBit,
  input  logic       cntLast,
  input  logic       addrHit,
  input  logic       rwBit,
  input  logic       txFull,
  input  logic       clrWr,
  input  logic [1:0] clrMask,
  output dpCtl_t     ctl,
  output logic       sclOe,
  output logic       dataRis,
  output logic       stopRis,
  output logic       qcmdSt,
  output logic       qcmdDir
);

  tgtState_t state, nextState;
  logic active, gotByte;
  logic setData, setStop, setQuick, matchNow, setGot, dropActive;

  always_comb begin
    nextState  = state;
    ctl        = '0;
    setData    = 1'b0;
    setStop    = 1'b0;
    setQuick   = 1'b0;
    matchNow   = 1'b0;
    setGot     = 1'b0;
    dropActive = 1'b0;
    ctl.drvAck = (state == ST_ACK_A) || (state == ST_ACK_R);
    ctl.drvTx  = (state == ST_TX);
    if (startSeen) begin
      nextState  = ST_ADDR;
      ctl.clrCnt = 1'b1;
      dropActive = 1'b1;
    end else if (stopSeen) begin
      nextState  = ST_IDLE;
      dropActive = 1'b1;
      if (active) begin
        setStop  = 1'b1;
        setQuick = ~gotByte;
      end
    end else begin
      unique case (state)
        ST_ADDR: if (sclRise) begin
          ctl.shiftIn = 1'b1;
          if (cntLast) nextState = ST_ADDR_END;
        end
        ST_ADDR_END: if (sclFall) begin
          if (addrHit) begin
            nextState   = ST_ACK_A;
            ctl.latchRw = 1'b1;
            matchNow    = 1'b1;
          end else begin
            nextState = ST_IDLE;
          end
        end
        ST_ACK_A: if (sclFall) begin
          ctl.clrCnt = 1'b1;
          if (rwBit) begin
            nextState = ST_WAIT_TX;
            setData   = 1'b1;
          end else begin
            nextState = ST_RX;
          end
        end
        ST_WAIT_TX: if (txFull) begin
          ctl.loadTx = 1'b1;
          ctl.clrCnt = 1'b1;
          nextState  = ST_TX;
        end
        ST_TX: if (sclFall) begin
          if (cntLast) begin
            nextState = ST_TX_ACK;
            setGot    = 1'b1;
          end else begin
            ctl.shiftTx = 1'b1;
          end
        end
        ST_TX_ACK: if (sclRise) begin
          nextState = sdaBit ? ST_IDLE : ST_TX_NEXT;
        end
        ST_TX_NEXT: if (sclFall) begin
          nextState = ST_WAIT_TX;
          setData   = 1'b1;
        end
        ST_RX: if (sclRise) begin
          ctl.shiftIn = 1'b1;
          if (cntLast) begin
            nextState   = ST_RX_END;
            ctl.latchRx = 1'b1;
            setData     = 1'b1;
            setGot      = 1'b1;
          end
        end
        ST_RX_END: if (sclFall) nextState = ST_ACK_R;
        ST_ACK_R: if (sclFall) begin
          nextState  = ST_RX;
          ctl.clrCnt = 1'b1;
        end
        default: nextState = state;
      endcase
    end
  end

  assign sclOe = (state == ST_WAIT_TX);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      active  <= 1'b0;
      gotByte <= 1'b0;
      dataRis <= 1'b0;
      stopRis <= 1'b0;
      qcmdSt  <= 1'b0;
      qcmdDir <= 1'b0;
    end else begin
      state <= nextState;
      if (matchNow) active <= 1'b1;
      else if (dropActive) active <= 1'b0;
      if (matchNow) gotByte <= 1'b0;
      else if (setGot) gotByte <= 1'b1;
      if (setData) dataRis <= 1'b1;
      else if (clrWr && clrMask[CLR_DATA_BIT]) dataRis <= 1'b0;
      if (setStop) stopRis <= 1'b1;
      else if (clrWr && clrMask[CLR_STOP_BIT]) stopRis <= 1'b0;
      if (matchNow) begin
        qcmdSt  <= 1'b0;
        qcmdDir <= 1'b0;
      end else if (setQuick) begin
        qcmdSt  <= 1'b1;
        qcmdDir <= rwBit;
      end
    end
  end

endmodule

// File: rtl/i2cq_target.sv
module i2cq_target
  import i2cq_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] devAddr,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sclOe,
  output logic              sdaOe,
  input  logic              txWr,
  input  logic [DATA_W-1:0] txData,
  input  logic              clrWr,
  input  logic [1:0]        clrMask,
  output logic [DATA_W-1:0] rxData,
  output logic              dataRis,
  output logic              stopRis,
  output logic              qcmdSt,
  output logic              qcmdDir
);

  dpCtl_t ctl;
  logic sclRise, sclFall, startSeen, stopSeen, sdaBit;
  logic cntLast, addrHit, rwBit, txFull;

  i2cq_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .devAddr(devAddr), .txWr(txWr), .txData(txData), .ctl(ctl),
    .sclRise(sclRise), .sclFall(sclFall), .startSeen(startSeen),
    .stopSeen(stopSeen), .sdaBit(sdaBit), .cntLast(cntLast),
    .addrHit(addrHit), .rwBit(rwBit), .txFull(txFull),
    .rxData(rxData), .sdaOe(sdaOe)
  );

  i2cq_control u_ctl (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .startSeen(startSeen), .stopSeen(stopSeen), .sdaBit(sdaBit),
    .cntLast(cntLast), .addrHit(addrHit), .rwBit(rwBit),
    .txFull(txFull), .clrWr(clrWr), .clrMask(clrMask), .ctl(ctl),
    .sclOe(sclOe), .dataRis(dataRis), .stopRis(stopRis),
    .qcmdSt(qcmdSt), .qcmdDir(qcmdDir)
  );

endmodule

// File: rtl/i2cq_checks.sv
module i2cq_checks (
  input logic clk,
  input logic rstN,
  input logic sclIn,
  input logic txWr,
  input logic sclOe,
  input logic sdaOe,
  input logic dataRis,
  input logic stopRis,
  input logic qcmdSt,
  input logic qcmdDir
);

  a_r1_reset_quiet: assert property (@(posedge clk)
    !rstN |-> (!dataRis && !stopRis && !qcmdSt && !qcmdDir && !sdaOe && !sclOe));

  a_r6_hold_after_request: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sclOe) |-> dataRis);

  a_r6_release_on_load: assert property (@(posedge clk) disable iff (!rstN)
    (sclOe && txWr) |-> ##2 !sclOe);

  a_r5_status_with_stop: assert property (@(posedge clk) disable iff (!rstN)
    $rose(qcmdSt) |-> stopRis);

  a_r9_dir_needs_status: assert property (@(posedge clk) disable iff (!rstN)
    qcmdDir |-> qcmdSt);

  a_r2_sda_change_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    (sclIn && $past(sclIn)) |-> $stable(sdaOe));

endmodule

bind i2cq_target i2cq_checks u_checks (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .txWr(txWr), .sclOe(sclOe),
  .sdaOe(sdaOe), .dataRis(dataRis), .stopRis(stopRis),
  .qcmdSt(qcmdSt), .qcmdDir(qcmdDir)
);

// File: tb/i2cq_target_bench.sv
module i2cq_target_bench;

  localparam int HALF = 20;
  localparam logic [6:0] OWN = 7'h42;

  typedef struct packed {
    logic [6:0] addr;
    logic       rw;
    logic [1:0] nBytes;
    logic [7:0] d0;
    logic [7:0] d1;
    logic       expAck;
    logic       expSt;
    logic       expDir;
    logic       expDr;
    logic       expSp;
  } vec_t;

  localparam vec_t VECS [0:5] = '{
    '{7'h42, 1'b0, 2'd0, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1},
    '{7'h17, 1'b0, 2'd1, 8'h99, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    '{7'h42, 1'b0, 2'd1, 8'h5A, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1},
    '{7'h42, 1'b1, 2'd0, 8'hFF, 8'h00, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1},
    '{7'h42, 1'b1, 2'd1, 8'hC3, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1},
    '{7'h42, 1'b0, 2'd2, 8'hA5, 8'h3C, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1}
  };

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rstN, mScl, mSda, sclLine, sdaLine;
  logic sclOe, sdaOe, txWr, clrWr;
  logic [7:0] txData, rxData;
  logic [1:0] clrMask;
  logic dataRis, stopRis, qcmdSt, qcmdDir;
  int nChk = 0;
  int nFail = 0;
  logic done = 1'b0;

  assign sclLine = mScl & ~sclOe;
  assign sdaLine = mSda & ~sdaOe;

  i2cq_target u_i2cq_target (
    .clk(clk), .rstN(rstN), .devAddr(OWN), .sclIn(sclLine), .sdaIn(sdaLine),
    .sclOe(sclOe), .sdaOe(sdaOe), .txWr(txWr), .txData(txData),
    .clrWr(clrWr), .clrMask(clrMask), .rxData(rxData), .dataRis(dataRis),
    .stopRis(stopRis), .qcmdSt(qcmdSt), .qcmdDir(qcmdDir)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic hw();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic waitSclHigh();
    while (!sclLine) @(negedge clk);
  endtask

  task automatic busStart();
    mSda = 1'b1; hw();
    mScl = 1'b1; waitSclHigh(); hw();
    mSda = 1'b0; hw();
    mScl = 1'b0; hw();
  endtask

  task automatic busStop();
    mSda = 1'b0; hw();
    mScl = 1'b1; waitSclHigh(); hw();
    mSda = 1'b1; hw();
  endtask

  task automatic sendBit(input logic b);
    mSda = b; hw();
    mScl = 1'b1; waitSclHigh(); hw();
    mScl = 1'b0; hw();
  endtask

  task automatic readBit(output logic b);
    mSda = 1'b1; hw();
    mScl = 1'b1; waitSclHigh();
    repeat (HALF / 2) @(negedge clk);
    b = sdaLine;
    repeat (HALF / 2) @(negedge clk);
    mScl = 1'b0; hw();
  endtask

  task automatic sendByte(input logic [7:0] v, output logic ack);
    for (int i = 7; i >= 0; i--) sendBit(v[i]);
    readBit(ack);
  endtask

  task automatic recvByte(output logic [7:0] v, input logic nack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      readBit(b);
      v[i] = b;
    end
    sendBit(nack);
  endtask

  task automatic hostLoad(input logic [7:0] v);
    @(negedge clk);
    txData = v; txWr = 1'b1;
    @(negedge clk);
    txWr = 1'b0;
  endtask

  task automatic hostClear(input logic [1:0] m);
    @(negedge clk);
    clrMask = m; clrWr = 1'b1;
    @(negedge clk);
    clrWr = 1'b0; clrMask = 2'b00;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog expired (all requirements) actual 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
      $finish;
    end
  end

  initial begin
    logic ack;
    logic [7:0] got;
    rstN = 1'b0; mScl = 1'b1; mSda = 1'b1;
    txWr = 1'b0; txData = 8'h00; clrWr = 1'b0; clrMask = 2'b00;
    repeat (5) @(negedge clk);
    // R1: state during reset
    chk("R1 flags in reset", {dataRis, stopRis, qcmdSt, qcmdDir}, 4'b0000);
    chk("R1 lines in reset", {sdaOe, sclOe}, 2'b00);
    rstN = 1'b1;
    hw();
    chk("R1 flags after reset", {dataRis, stopRis, qcmdSt, qcmdDir}, 4'b0000);
    chk("R1 rxData after reset", rxData, 8'h00);

    // Vector table: R2 R3 R4 R5 R7 R8 R9
    for (int i = 0; i < 6; i++) begin
      if (VECS[i].rw) hostLoad(VECS[i].d0);
      busStart();
      sendByte({VECS[i].addr, VECS[i].rw}, ack);
      chk($sformatf("R2 address ack vec %0d", i), ack, VECS[i].expAck);
      if (!ack) begin
        if (!VECS[i].rw) begin
          for (int k = 0; k < int'(VECS[i].nBytes); k++) begin
            sendByte(k == 0 ? VECS[i].d0 : VECS[i].d1, ack);
            chk($sformatf("R3 data ack vec %0d", i), ack, 1'b0);
            chk($sformatf("R3 rxData vec %0d", i), rxData,
                k == 0 ? VECS[i].d0 : VECS[i].d1);
          end
        end else if (VECS[i].nBytes != 2'd0) begin
          recvByte(got, 1'b1);
          chk($sformatf("R7 read byte vec %0d", i), got, VECS[i].d0);
        end
      end
      busStop();
      hw();
      chk($sformatf("R4 R5 R8 R9 qcmd flags vec %0d", i), {qcmdSt, qcmdDir},
          {VECS[i].expSt, VECS[i].expDir});
      chk($sformatf("R4 R5 R3 dataRis vec %0d", i), dataRis, VECS[i].expDr);
      chk($sformatf("R2 stopRis vec %0d", i), stopRis, VECS[i].expSp);
      hostClear(2'b11);
    end

    // R6: quick read with no byte preloaded holds SCL until the host writes
    busStart();
    sendByte({OWN, 1'b1}, ack);
    chk("R2 ack read address", ack, 1'b0);
    mSda = 1'b0; hw();
    mScl = 1'b1; hw(); hw();
    chk("R6 SCL held low", {sclOe, sclLine}, 2'b10);
    chk("R5 data request raised", dataRis, 1'b1);
    hostLoad(8'hFF);
    repeat (4) @(negedge clk);
    chk("R6 SCL released after load", sclOe, 1'b0);
    waitSclHigh(); hw();
    mSda = 1'b1; hw();
    chk("R5 quick read flags", {qcmdSt, qcmdDir, stopRis}, 3'b111);

    // R10: independent write-1-to-clear
    hostClear(2'b01);
    chk("R10 dataRis cleared", dataRis, 1'b0);
    chk("R10 stopRis kept", stopRis, 1'b1);
    hostClear(2'b10);
    chk("R10 stopRis cleared", stopRis, 1'b0);
    chk("R9 qcmd flags untouched by clear", {qcmdSt, qcmdDir}, 2'b11);

    // R8: a matching write with a byte clears the quick status
    busStart();
    sendByte({OWN, 1'b0}, ack);
    chk("R9 qcmd cleared at match", {qcmdSt, qcmdDir}, 2'b00);
    sendByte(8'h81, ack);
    chk("R3 rxData 81", rxData, 8'h81);
    busStop(); hw();
    chk("R8 no quick status after byte", qcmdSt, 1'b0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

endmodule